// File: doc/BRIEF.md
# Dual-Format Chroma Input Unpacker

This block accepts one video input port on a sample clock. The port has an 8-bit luma bus and an 8-bit chroma bus. Input can arrive in either of two layouts. In the 4:2:2 layout, every chroma word is complete, with U and V alternating between samples. In the 4:1:1 layout, only the upper half of the chroma bus is used. One U value and one V value are spread as two-bit slices over four consecutive samples.

The block gathers samples into groups of four, starting at the first sample of each active line. For each group it rebuilds the chroma values and converts luma and chroma to two's complement, each according to its own coding bit. It then re-emits the group as a 4:2:2 stream with U on even slots and V on odd slots. Latency is the same in both layouts, so luma stays aligned with chroma.

Top module: `chroma_unpacker`

## Requirements
- R1: After reset, `outValid`, `lumaOut` and `chromaOut` are all zero.
- R2: Samples are counted while `lineValid` is high. Each complete group of four consecutive samples produces exactly four consecutive cycles with `outValid` high, one output slot per cycle.
- R3: A sample taken in clock period t appears on the outputs in period t+4, in both layouts.
- R4: When a line ends before a group of four is complete, the leftover samples produce no output cycle.
- R5: With `lumaTwos`=0, the luma input is offset binary and is output with its MSB inverted. With `lumaTwos`=1, it is output unchanged.
- R6: `chromaTwos` applies the same rule to chroma, independently of the luma coding bit.
- R7: With `fmt422`=1, output chroma slot p of a group is the recoded chroma input of sample p: U on even slots, V on odd slots.
- R8: With `fmt422`=0, U is assembled as {s0[7:6], s1[7:6], s2[7:6], s3[7:6]} and V as {s0[5:4], s1[5:4], s2[5:4], s3[5:4]}, where sN is the chroma bus of sample N. Chroma wires 3..0 are ignored. Output slots 0 and 2 carry U, and slots 1 and 3 carry V.
- R9: Every rising edge of `lineValid` restarts the grouping at sample 0, whatever partial group the previous line left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineValid | input | 1 | High while the active-line samples are present |
| fmt422 | input | 1 | Layout select: 0 = 4:1:1, 1 = 4:2:2 |
| lumaTwos | input | 1 | Luma input coding: 0 = offset binary, 1 = two's complement |
| chromaTwos | input | 1 | Chroma input coding: 0 = offset binary, 1 = two's complement |
| lumaIn | input | DATA_W | Luma input bus |
| chromaIn | input | DATA_W | Chroma input bus |
| lumaOut | output | DATA_W | Luma output, two's complement |
| chromaOut | output | DATA_W | Chroma output, 4:2:2, two's complement |
| outValid | output | 1 | Marks an output slot |

## Verification
The bench builds the block with the default DATA_W of 8, which gives 2-bit chroma slices. At that width a 256-sample line whose data steps by odd increments covers every luma and chroma code. Running that line under all eight combinations of layout and coding bits sweeps every recode and every 4:1:1 slice placement. Short lines of 3, 5, 6 and 13 samples, each followed by a fresh line, reach the dropped-remainder and restart cases.

// File: rtl/unpk_pkg.sv
package unpk_pkg;
  localparam int GROUP = 4;
  localparam int PHASE_W = $clog2(GROUP);

  typedef struct packed {
    logic               capture;
    logic [PHASE_W-1:0] phase;
    logic               load;
    logic               shift;
  } unpkStrobe_t;
endpackage

// File: rtl/unpk_ctrl.sv
module unpk_ctrl
  import unpk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        lineValid,
  output unpkStrobe_t strobe,
  output logic        outValid
);
  localparam int LEFT_W = $clog2(GROUP + 1);

  logic               lineValidQ;
  logic [PHASE_W-1:0] phaseQ;
  logic [PHASE_W-1:0] curPhase;
  logic [LEFT_W-1:0]  leftQ;
  logic               rise;

  always_comb begin
    rise           = lineValid & ~lineValidQ;
    curPhase       = rise ? '0 : phaseQ;
    strobe.capture = lineValid;
    strobe.phase   = curPhase;
    strobe.load    = lineValid && (curPhase == PHASE_W'(GROUP - 1));
    strobe.shift   = (leftQ > LEFT_W'(1)) && !strobe.load;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineValidQ <= 1'b0;
      phaseQ     <= '0;
      leftQ      <= '0;
    end else begin
      lineValidQ <= lineValid;
      if (lineValid) phaseQ <= curPhase + PHASE_W'(1);
      if (strobe.load)        leftQ <= LEFT_W'(GROUP);
      else if (leftQ != '0)   leftQ <= leftQ - LEFT_W'(1);
    end
  end

  assign outValid = (leftQ != '0);

  // R2
  load_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> outValid);

  // R2
  left_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    leftQ <= LEFT_W'(GROUP));

  // R4
  load_span_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> ($past(lineValid, 1) && $past(lineValid, 2) && $past(lineValid, 3)));
endmodule

// File: rtl/unpk_datapath.sv
module unpk_datapath
  import unpk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  unpkStrobe_t       strobe,
  input  logic              fmt422,
  input  logic              lumaTwos,
  input  logic              chromaTwos,
  input  logic [DATA_W-1:0] lumaIn,
  input  logic [DATA_W-1:0] chromaIn,
  output logic [DATA_W-1:0] lumaOut,
  output logic [DATA_W-1:0] chromaOut
);
  localparam int SLICE_W = DATA_W / GROUP;

  logic [DATA_W-1:0] lumaBuf   [GROUP-1];
  logic [DATA_W-1:0] chromaBuf [GROUP-1];
  logic [DATA_W-1:0] lumaGrp   [GROUP];
  logic [DATA_W-1:0] chromaGrp [GROUP];
  logic [DATA_W-1:0] lumaBank  [GROUP];
  logic [DATA_W-1:0] chromaBank[GROUP];
  logic [DATA_W-1:0] uPacked;
  logic [DATA_W-1:0] vPacked;

  function automatic logic [DATA_W-1:0] recode(input logic [DATA_W-1:0] val, input logic twos);
    return twos ? val : {~val[DATA_W-1], val[DATA_W-2:0]};
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < GROUP - 1; i++) begin
        lumaBuf[i]   <= '0;
        chromaBuf[i] <= '0;
      end
    end else if (strobe.capture && (strobe.phase < PHASE_W'(GROUP - 1))) begin
      lumaBuf[strobe.phase]   <= lumaIn;
      chromaBuf[strobe.phase] <= chromaIn;
    end
  end

  generate
    for (genvar g = 0; g < GROUP; g++) begin : gGrp
      if (g < GROUP - 1) begin : gHeld
        assign lumaGrp[g]   = lumaBuf[g];
        assign chromaGrp[g] = chromaBuf[g];
      end else begin : gLive
        assign lumaGrp[g]   = lumaIn;
        assign chromaGrp[g] = chromaIn;
      end
      assign uPacked[DATA_W-1-g*SLICE_W -: SLICE_W] = chromaGrp[g][DATA_W-1 -: SLICE_W];
      assign vPacked[DATA_W-1-g*SLICE_W -: SLICE_W] = chromaGrp[g][DATA_W-1-SLICE_W -: SLICE_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < GROUP; i++) begin
        lumaBank[i]   <= '0;
        chromaBank[i] <= '0;
      end
    end else if (strobe.load) begin
      for (int i = 0; i < GROUP; i++) begin
        lumaBank[i]   <= recode(lumaGrp[i], lumaTwos);
        chromaBank[i] <= recode(fmt422 ? chromaGrp[i] : ((i % 2 == 0) ? uPacked : vPacked),
                                chromaTwos);
      end
    end else if (strobe.shift) begin
      for (int i = 0; i < GROUP - 1; i++) begin
        lumaBank[i]   <= lumaBank[i+1];
        chromaBank[i] <= chromaBank[i+1];
      end
    end
  end

  assign lumaOut   = lumaBank[0];
  assign chromaOut = chromaBank[0];

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.shift) |=> ($stable(lumaOut) && $stable(chromaOut)));
endmodule

// File: rtl/chroma_unpacker.sv
module chroma_unpacker
  import unpk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineValid,
  input  logic              fmt422,
  input  logic              lumaTwos,
  input  logic              chromaTwos,
  input  logic [DATA_W-1:0] lumaIn,
  input  logic [DATA_W-1:0] chromaIn,
  output logic [DATA_W-1:0] lumaOut,
  output logic [DATA_W-1:0] chromaOut,
  output logic              outValid
);
  unpkStrobe_t strobe;

  unpk_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .lineValid (lineValid),
    .strobe    (strobe),
    .outValid  (outValid)
  );

  unpk_datapath #(.DATA_W(DATA_W)) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .fmt422     (fmt422),
    .lumaTwos   (lumaTwos),
    .chromaTwos (chromaTwos),
    .lumaIn     (lumaIn),
    .chromaIn   (chromaIn),
    .lumaOut    (lumaOut),
    .chromaOut  (chromaOut)
  );
endmodule

// File: tb/test_chroma_unpacker.sv
module test_chroma_unpacker;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic       lineValid;
  logic       fmt422, lumaTwos, chromaTwos;
  logic [7:0] lumaIn, chromaIn;
  logic [7:0] lumaOut, chromaOut;
  logic       outValid;

  int compared = 0;
  int mismatched = 0;

  logic [7:0] lumaArr  [0:299];
  logic [7:0] chromaArr[0:299];

  chroma_unpacker #(.DATA_W(8)) i_chroma_unpacker (
    .clk(clk), .rstN(rstN), .lineValid(lineValid), .fmt422(fmt422),
    .lumaTwos(lumaTwos), .chromaTwos(chromaTwos), .lumaIn(lumaIn),
    .chromaIn(chromaIn), .lumaOut(lumaOut), .chromaOut(chromaOut),
    .outValid(outValid)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag,
                       input logic v, input logic [7:0] l, input logic [7:0] c,
                       input logic ev, input logic [7:0] el, input logic [7:0] ec);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: got valid=%0b luma=%02h chroma=%02h, expected valid=%0b luma=%02h chroma=%02h",
               tag, v, l, c, ev, el, ec);
    end
  endtask

  // Drives one line of len samples followed by four idle periods, checking every period.
  task automatic runLine(input int len, input int seed, input logic f,
                         input logic lt, input logic ct, input string tag);
    int full;
    full = (len / 4) * 4;
    for (int k = 0; k < len; k++) begin
      lumaArr[k]   = 8'((k * 37 + seed * 11) & 255);
      chromaArr[k] = 8'((k * 91 + seed * 53 + 5) & 255);
    end
    fmt422 = f; lumaTwos = lt; chromaTwos = ct;
    for (int k = 0; k < len + 4; k++) begin
      int idx;
      idx = k - 4;
      if (idx >= 0 && idx < full) begin
        int g, p;
        logic [7:0] el, ec, u, v, cc;
        g = idx - (idx % 4);
        p = idx % 4;
        u = {chromaArr[g][7:6], chromaArr[g+1][7:6], chromaArr[g+2][7:6], chromaArr[g+3][7:6]};
        v = {chromaArr[g][5:4], chromaArr[g+1][5:4], chromaArr[g+2][5:4], chromaArr[g+3][5:4]};
        cc = f ? chromaArr[idx] : ((p % 2 == 0) ? u : v);
        el = lt ? lumaArr[idx] : (lumaArr[idx] ^ 8'h80);
        ec = ct ? cc : (cc ^ 8'h80);
        check(outValid === 1'b1 && lumaOut === el && chromaOut === ec,
              {tag, (f ? " R2 R3 R5 R6 R7" : " R2 R3 R5 R6 R8")},
              outValid, lumaOut, chromaOut, 1'b1, el, ec);
      end else begin
        check(outValid === 1'b0, {tag, (idx >= full ? " R4 remainder dropped" : " R3 latency")},
              outValid, lumaOut, chromaOut, 1'b0, lumaOut, chromaOut);
      end
      if (k < len) begin
        lineValid = 1'b1;
        lumaIn    = lumaArr[k];
        chromaIn  = chromaArr[k];
      end else begin
        lineValid = 1'b0;
        lumaIn    = 8'h5A;
        chromaIn  = 8'hA5;
      end
      @(posedge clk); #1;
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    mismatched++;
    $display("FAIL watchdog: got no finish, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rstN = 1'b0; lineValid = 1'b0; fmt422 = 1'b0; lumaTwos = 1'b0; chromaTwos = 1'b0;
    lumaIn = 8'h00; chromaIn = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(outValid === 1'b0 && lumaOut === 8'h00 && chromaOut === 8'h00, "R1 reset",
          outValid, lumaOut, chromaOut, 1'b0, 8'h00, 8'h00);
    rstN = 1'b1;
    @(posedge clk); #1;
    check(outValid === 1'b0 && lumaOut === 8'h00 && chromaOut === 8'h00, "R1 after release",
          outValid, lumaOut, chromaOut, 1'b0, 8'h00, 8'h00);
    for (int cfg = 0; cfg < 8; cfg++) begin
      logic f, lt, ct;
      f = cfg[2]; lt = cfg[1]; ct = cfg[0];
      // Full code sweep (R5, R6, R7, R8)
      runLine(256, cfg, f, lt, ct, "sweep");
      // Partial groups, each followed by a fresh line (R4, R9)
      runLine(6, cfg + 3, f, lt, ct, "R4 partial");
      runLine(8, cfg + 5, f, lt, ct, "R9 restart");
      runLine(3, cfg + 7, f, lt, ct, "R4 short");
      runLine(13, cfg + 9, f, lt, ct, "R9 restart");
      runLine(5, cfg + 2, f, lt, ct, "R4 partial");
      runLine(4, cfg + 1, f, lt, ct, "R9 single group");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule